// File: doc/BRIEF.md
# MDIO Management Master with Bus Multiplexer

This block is a register-driven station-management master. One frame engine reaches PHYs on a set of MDIO buses split into an internal group and an external group. Software fills a parameter word with the group select, the bus number inside that group, the PHY address, the clause select and any write data. It puts the register (and, for Clause 45, device) address in an address word. It then clears the control word and writes an operation code. Completion is found by polling a done flag. Read data then sits in a read-data word.

MDC for each group is derived from the core clock by its own rate register. The rate register holds a divisor and a dividend. Only the chosen bus toggles MDC and drives MDIO. An ownership bit decides who drives the external buses. When it is clear, an outside management master drives them. When it is set, this engine owns them and the outside master's inputs are ignored.

The engine has four states. In `S_IDLE`, an accepted operation code moves it to `S_ADDR_FRAME` for Clause 45 or to `S_XFER_FRAME` for Clause 22. From `S_ADDR_FRAME`, the 64th sampled bit moves it to `S_XFER_FRAME`. From `S_XFER_FRAME`, the 64th sampled bit moves it to `S_DONE`. From `S_DONE`, a control write of zero returns it to `S_IDLE`.

Top module: `mdio_mux_master`

## Requirements
- R1: Parameter word (index 0) fields: write data [15:0], PHY address [20:16], Clause 45 select bit 21, bus number [24:22], internal-group select bit 25 (1 = internal buses 0..3, 0 = external buses 4..7). Only the selected bus toggles MDC or raises its output enable. Every other bus owned by the engine keeps MDC low and output enable low. A bus number of 4 or more selects no bus.
- R2: Control word (index 2): writing 1 starts a write and writing 2 starts a read. Any other nonzero code has no effect.
- R3: Status word (index 3) bit 0 is done. It is 0 after reset, becomes 1 when the transaction ends, stays 1 while the control word is not written with 0, and returns to 0 on a control write of 0.
- R4: Read-data word (index 4) holds the 16 bits read, with bits [31:16] zero. A read from a bus that is not connected returns 0xFFFF.
- R5: A Clause 22 frame is 32 ones, start 01, opcode 10 for read or 01 for write, 5 PHY bits, 5 register bits taken from address word [4:0], turnaround 10 on writes, and 16 data bits, all sent MSB first.
- R6: A Clause 45 operation sends an address frame first: start 00, opcode 00, PHY, device from address word [20:16], turnaround 10, and data equal to address word [15:0]. It then sends a frame with start 00, opcode 01 for write or 11 for read, and the same PHY and device. Both frames have a 32-one preamble.
- R7: A new MDIO bit is driven after a falling MDC edge and sampled at the rising edge. During the turnaround and the data bits of a read, output enable is low.
- R8: The MDC period is divisor x (dividend + 1) core clocks, with a minimum of 4. The divisor is in rate word bits [7:0] and the dividend is in bits [23:16]. Index 5 is the internal group's rate word and index 6 is the external group's. MDC is low when idle.
- R9: While a transaction is running, writes to the control word (start codes or zero) are ignored, and the frame and result are unchanged.
- R10: Ownership word (index 7) bit 28 is 0 after reset. While it is 0, the external buses follow the outside master's MDC, data and enable inputs, and `ext_mdi_o` is the AND of the external buses' inputs. While it is 1, those inputs are ignored.
- R11: Parameter, address, rate and ownership words read back what was written in their defined fields, with the other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdio_i | input | 8 | MDIO input per bus |
| mdc_o | output | 8 | MDC per bus |
| mdio_o | output | 8 | MDIO output value per bus |
| mdio_oe_o | output | 8 | MDIO output enable per bus |
| ext_mdc_i | input | 1 | Outside master MDC |
| ext_mdo_i | input | 1 | Outside master MDIO value |
| ext_mdoe_i | input | 1 | Outside master MDIO enable |
| ext_mdi_o | output | 1 | MDIO input returned to outside master |

## Verification
The assertions check on every cycle that:
- at most one engine-owned bus is active;
- the done flag holds until it is cleared and drops on a clear;
- the latched transaction fields do not move while a frame runs;
- output enable is low at each sample point of a read's turnaround and data;
- MDC phase agrees with the drive and sample ticks.

Only the bench's scenarios can show the full bit content of each frame for both clauses, the measured MDC period for each group's rate word, the returned read data and the 0xFFFF result from an empty bus, the rejection of invalid and mid-flight codes, and the hand-over of the external buses between the outside master and the engine.

// File: rtl/mdio_mux_pkg.sv
package mdio_mux_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR_FRAME,
        S_XFER_FRAME,
        S_DONE
    } eng_state_t;

    localparam logic [2:0] RA_PARAM    = 3'd0;
    localparam logic [2:0] RA_ADDR     = 3'd1;
    localparam logic [2:0] RA_CTRL     = 3'd2;
    localparam logic [2:0] RA_STAT     = 3'd3;
    localparam logic [2:0] RA_RDATA    = 3'd4;
    localparam logic [2:0] RA_RATE_INT = 3'd5;
    localparam logic [2:0] RA_RATE_EXT = 3'd6;
    localparam logic [2:0] RA_SCAN     = 3'd7;

    localparam int FP_PHY   = 16;
    localparam int FP_C45   = 21;
    localparam int FP_BUS   = 22;
    localparam int FP_INT   = 25;
    localparam int BUS_ID_W = 3;
    localparam int OWN_BIT  = 28;
    localparam int DVD_LSB  = 16;

    localparam logic [31:0] OPC_WRITE = 32'd1;
    localparam logic [31:0] OPC_READ  = 32'd2;

    // 32 frame bits after the preamble: start, opcode, port, register/device, turnaround, data
    function automatic logic [31:0] frame_word(logic [1:0] st, logic [1:0] op,
                                               logic [4:0] pa, logic [4:0] ra,
                                               logic [15:0] d);
        return {st, op, pa, ra, 2'b10, d};
    endfunction

endpackage

// File: rtl/mdio_rate_div.sv
module mdio_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    input  logic [DIV_W-1:0] dividend,
    output logic             mdc,
    output logic             fall_tick,
    output logic             rise_tick
);
    localparam int PW = 2 * DIV_W + 1;
    localparam logic [PW-1:0] MIN_P = PW'(4);

    logic [PW-1:0] prod, period, half, cnt;

    assign prod   = PW'(divisor) * (PW'(dividend) + PW'(1));
    assign period = (prod < MIN_P) ? MIN_P : prod;
    assign half   = period >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (!run)                    cnt <= '0;
        else if (cnt >= period - PW'(1))  cnt <= '0;
        else                              cnt <= cnt + PW'(1);
    end

    assign fall_tick = run && (cnt == '0);
    assign rise_tick = run && (cnt == half);
    assign mdc       = run && (cnt >= half);

    // MDC is low when a new bit is launched and high when it is sampled
    assert_launch_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |-> !mdc);
    assert_sample_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> (mdc && !fall_tick));
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mux_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        clear,
    input  logic        op_read,
    input  logic        c45,
    input  logic [4:0]  phy,
    input  logic [20:0] addr,
    input  logic [15:0] wdata,
    input  logic        fall_tick,
    input  logic        rise_tick,
    input  logic        mdi,
    output logic        run,
    output logic        idle,
    output logic        done,
    output logic        mdo,
    output logic        mdoe,
    output logic [15:0] rd_data
);
    eng_state_t state, nxt;

    logic [5:0]  idx;
    logic        rd_q, c45_q;
    logic [4:0]  phy_q;
    logic [20:0] addr_q;
    logic [15:0] wd_q;
    logic [31:0] frame;
    logic        last_bit, bit_val, release_bit;

    assign last_bit = rise_tick && (idx == 6'd63);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (start)    nxt = c45 ? S_ADDR_FRAME : S_XFER_FRAME;
            S_ADDR_FRAME: if (last_bit) nxt = S_XFER_FRAME;
            S_XFER_FRAME: if (last_bit) nxt = S_DONE;
            S_DONE:       if (clear)    nxt = S_IDLE;
            default:                    nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    assign run  = (state == S_ADDR_FRAME) || (state == S_XFER_FRAME);
    assign idle = (state == S_IDLE);
    assign done = (state == S_DONE);

    always_comb begin
        if (state == S_ADDR_FRAME)
            frame = frame_word(2'b00, 2'b00, phy_q, addr_q[20:16], addr_q[15:0]);
        else if (c45_q)
            frame = frame_word(2'b00, rd_q ? 2'b11 : 2'b01, phy_q, addr_q[20:16], wd_q);
        else
            frame = frame_word(2'b01, rd_q ? 2'b10 : 2'b01, phy_q, addr_q[4:0], wd_q);
    end

    assign bit_val     = idx[5] ? frame[~idx[4:0]] : 1'b1;
    assign release_bit = (state == S_XFER_FRAME) && rd_q && (idx >= 6'd46);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            rd_q    <= 1'b0;
            c45_q   <= 1'b0;
            phy_q   <= '0;
            addr_q  <= '0;
            wd_q    <= '0;
            mdo     <= 1'b1;
            mdoe    <= 1'b0;
            rd_data <= '0;
        end else begin
            if (idle && start) begin
                idx    <= '0;
                rd_q   <= op_read;
                c45_q  <= c45;
                phy_q  <= phy;
                addr_q <= addr;
                wd_q   <= wdata;
                if (op_read) rd_data <= '0;
            end
            if (run) begin
                if (fall_tick) begin
                    mdo  <= bit_val;
                    mdoe <= !release_bit;
                end
                if (rise_tick) begin
                    idx <= idx + 6'd1;
                    if ((state == S_XFER_FRAME) && rd_q && (idx >= 6'd48))
                        rd_data <= {rd_data[14:0], mdi};
                end
            end else begin
                mdo  <= 1'b1;
                mdoe <= 1'b0;
            end
        end
    end

    assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done);
    assert_busy_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start) |=> ($stable(phy_q) && $stable(rd_q) && $stable(addr_q)));
    assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_tick && (state == S_XFER_FRAME) && rd_q && (idx >= 6'd46)) |-> !mdoe);

endmodule

// File: rtl/mdio_bus_mux.sv
module mdio_bus_mux #(
    parameter int GRP  = 4,
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eng_mdc,
    input  logic            eng_mdo,
    input  logic            eng_mdoe,
    input  logic            sel_int,
    input  logic [ID_W-1:0] sel_id,
    input  logic            own_ext,
    input  logic            ext_mdc,
    input  logic            ext_mdo,
    input  logic            ext_mdoe,
    input  logic [2*GRP-1:0] mdio_i,
    output logic [2*GRP-1:0] mdc_o,
    output logic [2*GRP-1:0] mdio_o,
    output logic [2*GRP-1:0] mdio_oe_o,
    output logic            eng_mdi,
    output logic            ext_mdi
);
    localparam int NB = 2 * GRP;

    logic [NB-1:0] hit;

    for (genvar b = 0; b < NB; b++) begin : g_bus
        if (b < GRP) begin : g_int
            assign hit[b]       = sel_int && (sel_id == ID_W'(b));
            assign mdc_o[b]     = hit[b] & eng_mdc;
            assign mdio_o[b]    = hit[b] ? eng_mdo : 1'b1;
            assign mdio_oe_o[b] = hit[b] & eng_mdoe;
        end else begin : g_ext
            assign hit[b]       = !sel_int && own_ext && (sel_id == ID_W'(b - GRP));
            assign mdc_o[b]     = own_ext ? (hit[b] & eng_mdc) : ext_mdc;
            assign mdio_o[b]    = own_ext ? (hit[b] ? eng_mdo : 1'b1) : ext_mdo;
            assign mdio_oe_o[b] = own_ext ? (hit[b] & eng_mdoe) : ext_mdoe;
        end
    end

    assign eng_mdi = (|hit) ? |(hit & mdio_i) : 1'b1;
    assign ext_mdi = &mdio_i[NB-1:GRP];

    assert_one_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        own_ext |-> $onehot0(mdc_o | mdio_oe_o));
    assert_int_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_int |-> ((mdc_o[GRP-1:0] | mdio_oe_o[GRP-1:0]) == '0));
    assert_ext_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !own_ext |-> (mdc_o[NB-1:GRP] == {GRP{ext_mdc}}));

endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master
    import mdio_mux_pkg::*;
#(
    parameter int GRP   = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [2*GRP-1:0] mdio_i,
    output logic [2*GRP-1:0] mdc_o,
    output logic [2*GRP-1:0] mdio_o,
    output logic [2*GRP-1:0] mdio_oe_o,
    input  logic             ext_mdc_i,
    input  logic             ext_mdo_i,
    input  logic             ext_mdoe_i,
    output logic             ext_mdi_o
);
    localparam int PARAM_W = FP_INT + 1;

    logic [PARAM_W-1:0]  param_q;
    logic [20:0]         addr_q;
    logic [31:0]         ctrl_q;
    logic [DIV_W-1:0]    int_div_q, int_dvd_q, ext_div_q, ext_dvd_q;
    logic                own_q, sel_int_q;
    logic [BUS_ID_W-1:0] sel_id_q;

    logic wr_ctrl, start, clear;
    logic eng_run, eng_idle, eng_done, eng_mdo, eng_mdoe, eng_mdi;
    logic mdc_raw, fall_tick, rise_tick;
    logic [15:0] rd_data;

    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign start   = wr_ctrl && ((reg_wdata == OPC_WRITE) || (reg_wdata == OPC_READ));
    assign clear   = wr_ctrl && (reg_wdata == 32'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            param_q   <= '0;
            addr_q    <= '0;
            ctrl_q    <= '0;
            int_div_q <= '0;
            int_dvd_q <= '0;
            ext_div_q <= '0;
            ext_dvd_q <= '0;
            own_q     <= 1'b0;
            sel_int_q <= 1'b0;
            sel_id_q  <= '0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    RA_PARAM:    param_q <= reg_wdata[PARAM_W-1:0];
                    RA_ADDR:     addr_q  <= reg_wdata[20:0];
                    RA_CTRL:     ctrl_q  <= reg_wdata;
                    RA_RATE_INT: begin
                        int_div_q <= reg_wdata[DIV_W-1:0];
                        int_dvd_q <= reg_wdata[DVD_LSB +: DIV_W];
                    end
                    RA_RATE_EXT: begin
                        ext_div_q <= reg_wdata[DIV_W-1:0];
                        ext_dvd_q <= reg_wdata[DVD_LSB +: DIV_W];
                    end
                    RA_SCAN:     own_q <= reg_wdata[OWN_BIT];
                    default: ;
                endcase
            end
            if (start && eng_idle) begin
                sel_int_q <= param_q[FP_INT];
                sel_id_q  <= param_q[FP_BUS +: BUS_ID_W];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_PARAM:    reg_rdata = 32'(param_q);
            RA_ADDR:     reg_rdata = 32'(addr_q);
            RA_CTRL:     reg_rdata = ctrl_q;
            RA_STAT:     reg_rdata = {31'd0, eng_done};
            RA_RDATA:    reg_rdata = {16'd0, rd_data};
            RA_RATE_INT: reg_rdata = (32'(int_dvd_q) << DVD_LSB) | 32'(int_div_q);
            RA_RATE_EXT: reg_rdata = (32'(ext_dvd_q) << DVD_LSB) | 32'(ext_div_q);
            RA_SCAN:     reg_rdata = 32'(own_q) << OWN_BIT;
            default:     reg_rdata = '0;
        endcase
    end

    mdio_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_run),
        .divisor   (sel_int_q ? int_div_q : ext_div_q),
        .dividend  (sel_int_q ? int_dvd_q : ext_dvd_q),
        .mdc       (mdc_raw),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clear     (clear),
        .op_read   (reg_wdata == OPC_READ),
        .c45       (param_q[FP_C45]),
        .phy       (param_q[FP_PHY +: 5]),
        .addr      (addr_q),
        .wdata     (param_q[15:0]),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .mdi       (eng_mdi),
        .run       (eng_run),
        .idle      (eng_idle),
        .done      (eng_done),
        .mdo       (eng_mdo),
        .mdoe      (eng_mdoe),
        .rd_data   (rd_data)
    );

    mdio_bus_mux #(.GRP(GRP), .ID_W(BUS_ID_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_mdc   (mdc_raw),
        .eng_mdo   (eng_mdo),
        .eng_mdoe  (eng_mdoe),
        .sel_int   (sel_int_q),
        .sel_id    (sel_id_q),
        .own_ext   (own_q),
        .ext_mdc   (ext_mdc_i),
        .ext_mdo   (ext_mdo_i),
        .ext_mdoe  (ext_mdoe_i),
        .mdio_i    (mdio_i),
        .mdc_o     (mdc_o),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .eng_mdi   (eng_mdi),
        .ext_mdi   (ext_mdi_o)
    );

    assert_clear_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && clear) |=> !eng_done);
    assert_bad_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_idle && wr_ctrl && !start) |=> eng_idle);

endmodule

// File: tb/mdio_mux_master_tb.sv
module mdio_mux_master_tb;
    localparam int GRP = 4;
    localparam int NB  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NB-1:0] mdio_i, mdc_o, mdio_o, mdio_oe_o;
    logic [NB-1:0] resp_bits = '1;
    logic [NB-1:0] frc_bits = '1;
    logic ext_mdc_i = 1'b0, ext_mdo_i = 1'b1, ext_mdoe_i = 1'b0, ext_mdi_o;

    assign mdio_i = resp_bits & frc_bits;

    always #10 clk = ~clk;

    mdio_mux_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
        .ext_mdc_i(ext_mdc_i), .ext_mdo_i(ext_mdo_i), .ext_mdoe_i(ext_mdoe_i),
        .ext_mdi_o(ext_mdi_o)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit finished = 0;

    // reference model state
    logic [1:0] exp_q[$];
    int exp_bus = -1, exp_per = 6, last_rise = -1, rcnt = 0, resp_base = 0;
    int frame_err = 0, per_err = 0, idle_err = 0;
    logic [15:0] resp_data = '0;
    logic [NB-1:0] prev_mdc = '0;
    bit mon_en = 0, own_m = 0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (mon_en) begin
            for (int b = 0; b < NB; b++) begin
                if (b == exp_bus) begin
                    if (mdc_o[b] && !prev_mdc[b]) begin
                        if (exp_q.size() == 0) frame_err++;
                        else begin
                            logic [1:0] e;
                            e = exp_q.pop_front();
                            if (mdio_oe_o[b] != e[1] || (e[1] && mdio_o[b] != e[0])) frame_err++;
                        end
                        if (last_rise >= 0 && (cyc - last_rise) != exp_per) per_err++;
                        last_rise = cyc;
                        rcnt++;
                    end
                    if (!mdc_o[b] && prev_mdc[b]) begin
                        int k;
                        k = rcnt - resp_base;
                        resp_bits[b] = (k >= 48 && k < 64) ? resp_data[63 - k] : 1'b1;
                    end
                end else if (!(b >= GRP && !own_m) && (mdc_o[b] || mdio_oe_o[b])) begin
                    idle_err++;
                end
            end
        end
        prev_mdc = mdc_o;
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push_frame(logic [1:0] st, logic [1:0] op, logic [4:0] pa,
                              logic [4:0] ra, logic [15:0] d, bit rdf);
        logic [13:0] hdr;
        hdr = {st, op, pa, ra};
        repeat (32) exp_q.push_back(2'b11);
        for (int i = 13; i >= 0; i--) exp_q.push_back({1'b1, hdr[i]});
        if (rdf) repeat (18) exp_q.push_back(2'b00);
        else begin
            exp_q.push_back(2'b11);
            exp_q.push_back(2'b10);
            for (int i = 15; i >= 0; i--) exp_q.push_back({1'b1, d[i]});
        end
    endtask

    task automatic do_op(bit isint, int id, logic [4:0] phy, bit c45, logic [20:0] ra,
                         logic [15:0] wd, bit rdop, logic [15:0] resp, int bus, int per,
                         bit poke, output bit got_done);
        logic [31:0] s;
        logic [2:0] id3;
        id3 = 3'(id);
        exp_q.delete();
        frame_err = 0; per_err = 0; idle_err = 0;
        rcnt = 0; last_rise = -1; resp_data = resp; resp_base = c45 ? 64 : 0;
        exp_per = per; exp_bus = bus;
        if (c45) begin
            push_frame(2'b00, 2'b00, phy, ra[20:16], ra[15:0], 1'b0);
            push_frame(2'b00, rdop ? 2'b11 : 2'b01, phy, ra[20:16], wd, rdop);
        end else begin
            push_frame(2'b01, rdop ? 2'b10 : 2'b01, phy, ra[4:0], wd, rdop);
        end
        if (bus < 0) exp_q.delete();
        wr(3'd0, {6'd0, isint, id3, c45, phy, wd});
        wr(3'd1, {11'd0, ra});
        wr(3'd2, 32'd0);
        wr(3'd2, rdop ? 32'd2 : 32'd1);
        if (poke) begin
            repeat (100) @(negedge clk);
            wr(3'd2, 32'd1);
            wr(3'd2, 32'd0);
        end
        got_done = 0;
        for (int i = 0; i < 4000 && !got_done; i++) begin
            rd(3'd3, s);
            if (s[0]) got_done = 1;
        end
    endtask

    task automatic finish_op(string tag);
        chk(frame_err == 0 && exp_q.size() == 0, {tag, " frame bits"}, 32'(frame_err), 32'(exp_q.size()));
        chk(per_err == 0, {tag, " MDC period R8"}, 32'(per_err), 0);
        chk(idle_err == 0, {tag, " other buses idle R1"}, 32'(idle_err), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit dn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state R3 R11
        rd(3'd3, v); chk(v == 0, "R3 status after reset", v, 0);
        rd(3'd0, v); chk(v == 0, "R11 param after reset", v, 0);
        rd(3'd4, v); chk(v == 0, "R4 rdata after reset", v, 0);
        rd(3'd7, v); chk(v == 0, "R10 ownership after reset", v, 0);
        chk(mdc_o == 0 && mdio_oe_o == 0, "R8 MDC idle after reset", 32'(mdc_o), 0);

        wr(3'd5, 32'h0001_0003);   // 3 * 2 = 6 clocks
        wr(3'd6, 32'h0000_0005);   // 5 * 1 = 5 clocks
        wr(3'd7, 32'h1000_0000);
        own_m = 1;
        rd(3'd5, v); chk(v == 32'h0001_0003, "R11 rate readback", v, 32'h0001_0003);
        rd(3'd7, v); chk(v == 32'h1000_0000, "R11 ownership readback", v, 32'h1000_0000);
        mon_en = 1;

        // Clause 22 write, internal bus 1
        do_op(1, 1, 5'd5, 0, 21'h12, 16'hA5C3, 0, 16'h0, 1, 6, 0, dn);
        chk(dn, "R3 done after C22 write", 32'(dn), 1);
        finish_op("R5 C22 write");
        repeat (20) @(negedge clk);
        rd(3'd3, v); chk(v == 1, "R3 done holds", v, 1);
        wr(3'd2, 32'd0);
        rd(3'd3, v); chk(v == 0, "R3 done cleared", v, 0);

        // Clause 22 read, internal bus 2
        do_op(1, 2, 5'h1F, 0, 21'h3, 16'h0, 1, 16'h1234, 2, 6, 0, dn);
        chk(dn, "R3 done after C22 read", 32'(dn), 1);
        finish_op("R7 C22 read");
        rd(3'd4, v); chk(v == 32'h1234, "R4 C22 read data", v, 32'h1234);

        // Clause 45 write, external bus 0 (bus 4)
        do_op(0, 0, 5'd9, 1, {5'd3, 16'hBEEF}, 16'h55AA, 0, 16'h0, 4, 5, 0, dn);
        chk(dn, "R3 done after C45 write", 32'(dn), 1);
        finish_op("R6 C45 write");

        // Clause 45 read, external bus 3 (bus 7)
        do_op(0, 3, 5'd2, 1, {5'd1, 16'h0001}, 16'h0, 1, 16'hC0DE, 7, 5, 0, dn);
        chk(dn, "R3 done after C45 read", 32'(dn), 1);
        finish_op("R6 C45 read");
        rd(3'd4, v); chk(v == 32'hC0DE, "R4 C45 read data", v, 32'hC0DE);

        // control writes during a running read are ignored
        do_op(1, 0, 5'd1, 0, 21'h1, 16'h0, 1, 16'h8001, 0, 6, 1, dn);
        chk(dn, "R9 done despite mid-flight writes", 32'(dn), 1);
        finish_op("R9 poked read");
        rd(3'd4, v); chk(v == 32'h8001, "R9 read data unchanged", v, 32'h8001);
        wr(3'd2, 32'd0);

        // invalid code 3 starts nothing
        exp_bus = -1; idle_err = 0;
        wr(3'd2, 32'd3);
        repeat (60) @(negedge clk);
        rd(3'd3, v); chk(v == 0, "R2 code 3 no done", v, 0);
        chk(idle_err == 0, "R2 code 3 no bus activity", 32'(idle_err), 0);

        // bus number out of range: no bus moves, read returns ones
        do_op(1, 5, 5'd1, 0, 21'h2, 16'h0, 1, 16'h0, -1, 6, 0, dn);
        chk(dn, "R1 out-of-range done", 32'(dn), 1);
        chk(idle_err == 0, "R1 out-of-range no bus active", 32'(idle_err), 0);
        rd(3'd4, v); chk(v == 32'hFFFF, "R4 unconnected read", v, 32'hFFFF);
        wr(3'd2, 32'd0);

        // ownership hand-over R10
        mon_en = 0;
        wr(3'd7, 32'd0);
        own_m = 0;
        ext_mdc_i = 1'b1; ext_mdo_i = 1'b0; ext_mdoe_i = 1'b1;
        frc_bits = 8'hDF;
        @(negedge clk); #1;
        chk(mdc_o == 8'hF0, "R10 external MDC follows", 32'(mdc_o), 32'hF0);
        chk(mdio_oe_o == 8'hF0 && mdio_o[7:4] == 4'h0, "R10 external data follows",
            32'({mdio_oe_o, mdio_o}), 32'hF0_0F);
        chk(ext_mdi_o == 1'b0, "R10 ext_mdi is AND", 32'(ext_mdi_o), 0);
        wr(3'd7, 32'h1000_0000);
        @(negedge clk); #1;
        chk(mdc_o == 8'h00 && mdio_oe_o == 8'h00, "R10 outside master blocked",
            32'({mdc_o, mdio_oe_o}), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule